// File: doc/BRIEF.md
# Two-Dice Point Game Referee

This block runs a two-dice game of chance in which the first throw can end the game at once, and otherwise fixes a target value that later throws must reach before a seven comes up. Two dice counters live inside the block. While the player holds the roll input high, the first die counts 1 to 6 on every clock. The second die steps each time the first one wraps, so the pair walks through all 36 combinations. When the player lets go of roll, the block adds the two faces and judges the throw.

A throw is judged only on release, so a press of any length counts as one throw. The first throw of a game either decides it or loads a point register. Each later throw is compared with that point and with seven. A decided game keeps its win or lose flag set and ignores further throws until new_game is pulsed. For directed testing, an override input lets the sum be taken from two face values supplied at the ports instead of the counters.

Top module: `dice_referee`

## Requirements
- R1: While rst is high (synchronous, active-high), both dice are set to 1 and point, last_sum, win and lose are all 0. The game is then waiting for a first throw.
- R2: While roll is high, die_a advances 1,2,...,6,1 on every clock. die_b advances 1..6 cyclically on each clock where die_a wraps from 6 to 1. While roll is low, both dice hold their values.
- R3: A throw is judged on the first clock edge where roll is low after having been high on the previous edge. The sum of the two faces in use is registered into last_sum on that edge, and no other edge changes last_sum, point, win or lose except new_game and rst.
- R4: On the first throw of a game, a sum of 7 or 11 sets win.
- R5: On the first throw of a game, a sum of 2, 3 or 12 sets lose.
- R6: On the first throw of a game, a sum of 4, 5, 6, 8, 9 or 10 is loaded into point, and win and lose stay 0. point is 0 whenever no point is held.
- R7: On a later throw, a sum equal to point sets win.
- R8: On a later throw, a sum of 7 sets lose.
- R9: On a later throw whose sum is neither point nor 7, win and lose stay 0 and point is unchanged, and the player throws again.
- R10: Once win or lose is set, it stays set and throws are ignored (last_sum and point unchanged). A new_game pulse in any state clears win, lose and point on the next edge and returns to the first-throw state. new_game takes priority over a throw on the same edge. win and lose are never both 1.
- R11: While force_en is high, the judged sum is force_a + force_b (each 1..6) in place of the dice counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| roll | input | 1 | Held high to shake the dice; the throw happens on release |
| new_game | input | 1 | One-cycle pulse that starts a fresh game |
| force_en | input | 1 | Use force_a/force_b instead of the dice counters |
| force_a | input | DW (3) | Override face for the first die |
| force_b | input | DW (3) | Override face for the second die |
| die_a | output | DW (3) | Current face of the first die counter |
| die_b | output | DW (3) | Current face of the second die counter |
| last_sum | output | SW (4) | Sum of the most recently judged throw |
| point | output | SW (4) | Stored point, 0 when none |
| win | output | 1 | Game won |
| lose | output | 1 | Game lost |

## Verification
The assertions check on every cycle that win and lose are exclusive and persist until new_game, that new_game clears the game on the next edge, and that the dice stay in range and hold while roll is low. They also check that a held point is always a legal point value, and that nothing in the game changes on an edge that is not a release. Whether each sum is judged correctly, on the first throw and on later throws, can only be shown by the bench's scenarios. The bench covers all 36 forced face pairs, point games that end in both outcomes after a neutral throw, and the cascaded walk of the free-running dice.

// File: rtl/dice_referee.sv
module dice_referee #(
  parameter int DW = 3,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          roll,
  input  logic          new_game,
  input  logic          force_en,
  input  logic [DW-1:0] force_a,
  input  logic [DW-1:0] force_b,
  output logic [DW-1:0] die_a,
  output logic [DW-1:0] die_b,
  output logic [SW-1:0] last_sum,
  output logic [SW-1:0] point,
  output logic          win,
  output logic          lose
);
  localparam logic [DW-1:0] FACE_MIN = DW'(1);
  localparam logic [DW-1:0] FACE_MAX = DW'(6);

  typedef enum logic [1:0] {S_FIRST, S_POINT, S_WON, S_LOST} st_t;
  st_t st, st_n;

  logic          roll_q;
  logic          thrown;
  logic          a_wrap;
  logic [DW-1:0] a_use, b_use;
  logic [SW-1:0] sum;
  logic          natural_w, craps_w, seven_w;

  assign thrown = roll_q & ~roll;
  assign a_wrap = (die_a == FACE_MAX);
  assign a_use  = force_en ? force_a : die_a;
  assign b_use  = force_en ? force_b : die_b;
  assign sum    = SW'(a_use) + SW'(b_use);

  assign seven_w   = (sum == SW'(7));
  assign natural_w = seven_w || (sum == SW'(11));
  assign craps_w   = (sum == SW'(2)) || (sum == SW'(3)) || (sum == SW'(12));

  always_ff @(posedge clk) begin
    if (rst) begin
      roll_q <= 1'b0;
      die_a  <= FACE_MIN;
      die_b  <= FACE_MIN;
    end else begin
      roll_q <= roll;
      if (roll) begin
        die_a <= a_wrap ? FACE_MIN : die_a + FACE_MIN;
        if (a_wrap)
          die_b <= (die_b == FACE_MAX) ? FACE_MIN : die_b + FACE_MIN;
      end
    end
  end

  always_comb begin
    st_n = st;
    if (new_game) begin
      st_n = S_FIRST;
    end else if (thrown) begin
      case (st)
        S_FIRST: begin
          if (natural_w)    st_n = S_WON;
          else if (craps_w) st_n = S_LOST;
          else              st_n = S_POINT;
        end
        S_POINT: begin
          if (sum == point) st_n = S_WON;
          else if (seven_w) st_n = S_LOST;
        end
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_FIRST;
      point    <= '0;
      last_sum <= '0;
    end else begin
      st <= st_n;
      if (new_game)
        point <= '0;
      else if (thrown && st == S_FIRST && st_n == S_POINT)
        point <= sum;
      if (!new_game && thrown && (st == S_FIRST || st == S_POINT))
        last_sum <= sum;
    end
  end

  assign win  = (st == S_WON);
  assign lose = (st == S_LOST);
endmodule

module dice_referee_chk #(
  parameter int DW = 3,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          roll,
  input logic          roll_q,
  input logic          new_game,
  input logic [DW-1:0] die_a,
  input logic [DW-1:0] die_b,
  input logic [SW-1:0] last_sum,
  input logic [SW-1:0] point,
  input logic          win,
  input logic          lose
);
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(win && lose));

  assert_win_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (win && !new_game) |=> win);

  assert_lose_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (lose && !new_game) |=> lose);

  assert_new_game_R10: assert property (@(posedge clk) disable iff (rst)
    new_game |=> (!win && !lose && point == '0));

  assert_die_range_R2: assert property (@(posedge clk) disable iff (rst)
    (die_a >= DW'(1) && die_a <= DW'(6) && die_b >= DW'(1) && die_b <= DW'(6)));

  assert_die_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !roll |=> ($stable(die_a) && $stable(die_b)));

  assert_point_legal_R6: assert property (@(posedge clk) disable iff (rst)
    (point == '0 || point == SW'(4) || point == SW'(5) || point == SW'(6) ||
     point == SW'(8) || point == SW'(9) || point == SW'(10)));

  assert_no_throw_R3: assert property (@(posedge clk) disable iff (rst)
    (!(roll_q && !roll) && !new_game) |=>
      ($stable(point) && $stable(last_sum) && $stable(win) && $stable(lose)));
endmodule

bind dice_referee dice_referee_chk #(.DW(DW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .roll(roll), .roll_q(roll_q), .new_game(new_game),
  .die_a(die_a), .die_b(die_b), .last_sum(last_sum), .point(point),
  .win(win), .lose(lose)
);

// File: tb/sim_dice_referee.sv
module sim_dice_referee;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 3;
  localparam int SW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic roll = 1'b0;
  logic new_game = 1'b0;
  logic force_en = 1'b0;
  logic [DW-1:0] force_a = '0, force_b = '0;
  logic [DW-1:0] die_a, die_b;
  logic [SW-1:0] last_sum, point;
  logic win, lose;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dice_referee #(.DW(DW), .SW(SW)) u0 (
    .clk(clk), .rst(rst), .roll(roll), .new_game(new_game),
    .force_en(force_en), .force_a(force_a), .force_b(force_b),
    .die_a(die_a), .die_b(die_b), .last_sum(last_sum), .point(point),
    .win(win), .lose(lose)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic forced_roll(input int a, input int b);
    @(negedge clk);
    force_en = 1'b1; force_a = DW'(a); force_b = DW'(b); roll = 1'b1;
    @(negedge clk);
    roll = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_new;
    @(negedge clk);
    new_game = 1'b1;
    @(negedge clk);
    new_game = 1'b0;
  endtask

  task automatic split(input int s, output int a, output int b);
    a = s / 2;
    b = s - a;
  endtask

  task automatic check_state(input string tag, input int w, input int l, input int p);
    chk({tag, " win"}, int'(win), w);
    chk({tag, " lose"}, int'(lose), l);
    chk({tag, " point"}, int'(point), p);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int a, b, s, n, ew, el, ep, ls;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 die_a", int'(die_a), 1);
    chk("R1 die_b", int'(die_b), 1);
    chk("R1 last_sum", int'(last_sum), 0);
    check_state("R1", 0, 0, 0);
    rst = 1'b0;

    // R2 free-running dice walk, then R3 unforced throw on release
    roll = 1'b1;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      chk("R2 die_a", int'(die_a), (j % 6) + 1);
      chk("R2 die_b", int'(die_b), ((j / 6) % 6) + 1);
    end
    a = int'(die_a); b = int'(die_b);
    roll = 1'b0;
    @(negedge clk);
    chk("R2 hold die_a", int'(die_a), a);
    chk("R2 hold die_b", int'(die_b), b);
    chk("R3 last_sum", int'(last_sum), a + b);
    @(negedge clk);
    chk("R3 single throw", int'(last_sum), a + b);

    // R4 R5 R6 R11 every forced first-throw pair
    for (int fa = 1; fa <= 6; fa++) begin
      for (int fb = 1; fb <= 6; fb++) begin
        pulse_new();
        forced_roll(fa, fb);
        s = fa + fb;
        ew = (s == 7 || s == 11) ? 1 : 0;
        el = (s == 2 || s == 3 || s == 12) ? 1 : 0;
        ep = (ew == 0 && el == 0) ? s : 0;
        chk("R11 forced sum", int'(last_sum), s);
        check_state("R4 R5 R6 first throw", ew, el, ep);
      end
    end

    // R7 R8 R9 R10 point games
    for (int p = 4; p <= 10; p++) begin
      if (p == 7) continue;
      for (int mode = 0; mode < 2; mode++) begin
        pulse_new();
        split(p, a, b);
        forced_roll(a, b);
        check_state("R6 set point", 0, 0, p);
        n = (p == 4) ? 5 : 4;
        split(n, a, b);
        forced_roll(a, b);
        chk("R9 neutral sum", int'(last_sum), n);
        check_state("R9 roll again", 0, 0, p);
        forced_roll(1, 1);
        check_state("R9 later 2 not loss", 0, 0, p);
        if (mode == 0) begin
          split(p, a, b);
          forced_roll(a, b);
          check_state("R7 hit point", 1, 0, p);
        end else begin
          forced_roll(3, 4);
          check_state("R8 seven out", 0, 1, p);
        end
        ls = int'(last_sum);
        forced_roll(3, 4);
        forced_roll(6, 5);
        chk("R10 terminal last_sum", int'(last_sum), ls);
        check_state("R10 terminal hold", mode == 0 ? 1 : 0, mode == 1 ? 1 : 0, p);
        pulse_new();
        check_state("R10 cleared", 0, 0, 0);
      end
    end

    // R10 new_game from point state, with a release on the same edge
    pulse_new();
    forced_roll(4, 4);
    check_state("R10 pre", 0, 0, 8);
    @(negedge clk);
    force_a = 3'd4; force_b = 3'd4; roll = 1'b1;
    @(negedge clk);
    roll = 1'b0; new_game = 1'b1;
    @(negedge clk);
    new_game = 1'b0;
    check_state("R10 priority", 0, 0, 0);
    chk("R10 priority last_sum", int'(last_sum), 8);
    forced_roll(5, 6);
    check_state("R10 fresh first throw", 1, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule